// File: doc/BRIEF.md
# Ring-Oscillator Frequency Comparator

This block decides whether a ring oscillator on the regulated supply runs faster than a reference clock. It gives a single verdict, `fast_o`, and a one-cycle `enable_o` pulse that says a fresh verdict is ready. A voltage controller uses the verdict to step the supply up or down. After each step it asks for a new comparison with a one-cycle `start_req`.

A request first drops an internal arm level. The block then waits `CLR_WAIT` system cycles so that the oscillator and reference logic clear. After that it raises arm again. In the reference domain, the first reference cycle after arming is skipped, because it starts at an arbitrary point relative to the oscillator. The next full reference cycle opens a sampling window. Two oscillator-clocked flip-flops record whether one or two oscillator edges saw the window open. A reference-clocked flip-flop captures the two-edge flag once the window has closed and settled. The verdict and a completion flag cross into the system clock domain through synchronisers of `SYNC_STAGES` flops. The system-domain state machine then issues the enable pulse.

The control states are S_IDLE, S_CLEAR, S_ARMED, S_REPORT and S_HOLD, with these transitions:
- S_IDLE → S_CLEAR on a start request.
- S_CLEAR → S_ARMED when the clear count expires.
- S_ARMED → S_REPORT when the synchronised completion flag is seen.
- S_REPORT → S_HOLD unconditionally.
- S_HOLD → S_CLEAR on a start request.

The reference-side states are R_IDLE, R_LEAD, R_OPEN, R_SETTLE, R_CAPT and R_DONE. Each armed reference edge advances them by one state. Any reference edge with arm low returns them to R_IDLE.

Top module: `rofreq_cmp`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `fast_o` and `enable_o` are both 0.
- R2: After a start request, if the oscillator period is at most 0.4 of the reference period, the next enable pulse comes with `fast_o` = 1.
- R3: After a start request, if the oscillator period is at least 1.25 of the reference period, the next enable pulse comes with `fast_o` = 0.
- R4: Each accepted start request produces exactly one `enable_o` pulse, exactly one system-clock cycle wide. It arrives within 2000 system cycles when `CLR_WAIT` = 64 and both clock periods are below 400 ns.
- R5: `fast_o` changes only in the cycle where `enable_o` is high. Between pulses it holds the last verdict, even when the oscillator frequency changes.
- R6: After an enable pulse, no further pulse is issued until a new start request arrives.
- R7: A start request that arrives while a comparison is in progress is ignored. The ongoing comparison yields one pulse only.
- R8: Each new comparison starts from cleared internal state. Its verdict depends only on the clock periods in force during that comparison, never on the previous verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock; both outputs are registered on it |
| rst | input | 1 | Asynchronous active-high reset for all three domains |
| osc_clk | input | 1 | Ring-oscillator output used as a clock |
| ref_clk | input | 1 | Reference clock giving the target frequency |
| start_req | input | 1 | One-cycle request for a new comparison (system domain) |
| fast_o | output | 1 | 1 when the oscillator was found faster than the reference |
| enable_o | output | 1 | One-cycle pulse marking a newly valid `fast_o` |

## Verification
The bench builds the block with `CLR_WAIT` = 64 and `SYNC_STAGES` = 2. The short clear wait lets it run dozens of comparisons within the cycle budget. Reference periods are 40–120 ns and oscillator periods reach 360 ns, which still leaves at least three oscillator cycles inside the clear wait. Oscillator periods are drawn only from the two guaranteed bands, 0.15–0.4 and 1.25–3 times the reference period, so the verdict is unambiguous whatever the edge phases. Both band limits appear as directed cases. The bench also covers alternating verdicts, a duplicate request during a comparison, and a frequency change while the block is holding its verdict.

// File: rtl/rofreq_pkg.sv
package rofreq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLEAR,
        S_ARMED,
        S_REPORT,
        S_HOLD
    } ctl_st_t;

    typedef enum logic [2:0] {
        R_IDLE,
        R_LEAD,
        R_OPEN,
        R_SETTLE,
        R_CAPT,
        R_DONE
    } ref_st_t;

endpackage

// File: rtl/rofreq_sync.sv
module rofreq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rofreq_detect.sv
module rofreq_detect
    import rofreq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic ref_clk,
    input  logic rst,
    input  logic arm,
    output logic fast_r,
    output logic done_r
);
    logic    arm_ref;
    logic    arm_osc;
    ref_st_t rst_st;
    ref_st_t rst_nx;
    logic    win;
    logic    seen1;
    logic    seen2;

    rofreq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_arm_ref (
        .clk(ref_clk), .rst(rst), .d(arm), .q(arm_ref)
    );

    rofreq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_arm_osc (
        .clk(osc_clk), .rst(rst), .d(arm), .q(arm_osc)
    );

    // Reference side: skip the lead cycle, open one full window, settle, capture.
    always_comb begin
        rst_nx = rst_st;
        if (!arm_ref) begin
            rst_nx = R_IDLE;
        end else begin
            unique case (rst_st)
                R_IDLE:   rst_nx = R_LEAD;
                R_LEAD:   rst_nx = R_OPEN;
                R_OPEN:   rst_nx = R_SETTLE;
                R_SETTLE: rst_nx = R_CAPT;
                R_CAPT:   rst_nx = R_DONE;
                R_DONE:   rst_nx = R_DONE;
                default:  rst_nx = R_IDLE;
            endcase
        end
    end

    always_ff @(posedge ref_clk or posedge rst) begin
        if (rst) rst_st <= R_IDLE;
        else     rst_st <= rst_nx;
    end

    always_ff @(posedge ref_clk or posedge rst) begin
        if (rst) begin
            win    <= 1'b0;
            fast_r <= 1'b0;
            done_r <= 1'b0;
        end else begin
            win    <= (rst_nx == R_OPEN);
            done_r <= (rst_nx == R_DONE);
            if (rst_nx == R_IDLE)      fast_r <= 1'b0;
            else if (rst_nx == R_CAPT) fast_r <= seen2;
        end
    end

    // Oscillator side: first and second edge seeing the window open.
    always_ff @(posedge osc_clk or posedge rst) begin
        if (rst) begin
            seen1 <= 1'b0;
            seen2 <= 1'b0;
        end else if (!arm_osc) begin
            seen1 <= 1'b0;
            seen2 <= 1'b0;
        end else begin
            seen1 <= seen1 | win;
            seen2 <= seen2 | (seen1 & win);
        end
    end
endmodule

// File: rtl/rofreq_ctrl.sv
module rofreq_ctrl
    import rofreq_pkg::*;
#(
    parameter int CLR_WAIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic done_s,
    input  logic fast_s,
    output logic arm,
    output logic enable_o,
    output logic fast_o
);
    localparam int CW = $clog2(CLR_WAIT + 1);

    ctl_st_t        st;
    ctl_st_t        st_nx;
    logic [CW-1:0]  cnt;

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (start_req) st_nx = S_CLEAR;
            S_CLEAR:  if (cnt == CW'(CLR_WAIT - 1)) st_nx = S_ARMED;
            S_ARMED:  if (done_s) st_nx = S_REPORT;
            S_REPORT: st_nx = S_HOLD;
            S_HOLD:   if (start_req) st_nx = S_CLEAR;
            default:  st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= (st == S_CLEAR) ? cnt + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            arm      <= 1'b0;
            enable_o <= 1'b0;
            fast_o   <= 1'b0;
        end else begin
            arm      <= (st_nx == S_ARMED) || (st_nx == S_REPORT) || (st_nx == S_HOLD);
            enable_o <= (st_nx == S_REPORT);
            if (st_nx == S_REPORT) fast_o <= fast_s;
        end
    end
endmodule

// File: rtl/rofreq_cmp.sv
module rofreq_cmp #(
    parameter int CLR_WAIT    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_sys,
    input  logic rst,
    input  logic osc_clk,
    input  logic ref_clk,
    input  logic start_req,
    output logic fast_o,
    output logic enable_o
);
    logic arm;
    logic fast_r;
    logic done_r;
    logic fast_s;
    logic done_s;

    rofreq_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .osc_clk(osc_clk), .ref_clk(ref_clk), .rst(rst), .arm(arm),
        .fast_r(fast_r), .done_r(done_r)
    );

    rofreq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_res_sync (
        .clk(clk_sys), .rst(rst), .d({done_r, fast_r}), .q({done_s, fast_s})
    );

    rofreq_ctrl #(.CLR_WAIT(CLR_WAIT)) u_ctl (
        .clk(clk_sys), .rst(rst), .start_req(start_req), .done_s(done_s),
        .fast_s(fast_s), .arm(arm), .enable_o(enable_o), .fast_o(fast_o)
    );
endmodule

// File: rtl/rofreq_cmp_chk.sv
module rofreq_cmp_chk (
    input logic clk_sys,
    input logic rst,
    input logic start_req,
    input logic fast_o,
    input logic enable_o
);
    logic reported;

    always_ff @(posedge clk_sys or posedge rst) begin
        if (rst)            reported <= 1'b0;
        else if (enable_o)  reported <= 1'b1;
        else if (start_req) reported <= 1'b0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_sys)
        rst |=> (!enable_o && !fast_o));

    assert_pulse_width_R4: assert property (@(posedge clk_sys) disable iff (rst)
        enable_o |=> !enable_o);

    assert_fast_hold_R5: assert property (@(posedge clk_sys) disable iff (rst)
        !$stable(fast_o) |-> enable_o);

    assert_one_report_R6: assert property (@(posedge clk_sys) disable iff (rst)
        enable_o |-> !reported);
endmodule

bind rofreq_cmp rofreq_cmp_chk u_chk (
    .clk_sys(clk_sys), .rst(rst), .start_req(start_req),
    .fast_o(fast_o), .enable_o(enable_o)
);

// File: tb/sim_rofreq_cmp.sv
`timescale 1ns/1ps
module sim_rofreq_cmp;
    logic clk_sys = 1'b0;
    logic osc_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0;
    logic fast_o;
    logic enable_o;

    real ref_half = 40.0;
    real osc_half = 10.0;
    int  n_vec = 0;
    int  n_bad = 0;
    int  cyc = 0;
    bit  finished = 1'b0;

    rofreq_cmp #(.CLR_WAIT(64), .SYNC_STAGES(2)) u0 (
        .clk_sys(clk_sys), .rst(rst), .osc_clk(osc_clk), .ref_clk(ref_clk),
        .start_req(start_req), .fast_o(fast_o), .enable_o(enable_o)
    );

    always #10 clk_sys = ~clk_sys;
    initial begin #3.3; forever #(ref_half) ref_clk = ~ref_clk; end
    initial begin #1.7; forever #(osc_half) osc_clk = ~osc_clk; end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    always @(posedge clk_sys) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog", cyc, 150000);
            summary();
            $finish;
        end
    end

    function automatic bit exp_fast(input real osc_per, input real ref_per);
        return (osc_per <= 0.4 * ref_per);
    endfunction

    task automatic set_clocks(input real ref_per, input real osc_per);
        ref_half = ref_per / 2.0;
        osc_half = osc_per / 2.0;
    endtask

    task automatic pulse_start();
        @(negedge clk_sys) start_req = 1'b1;
        @(negedge clk_sys) start_req = 1'b0;
    endtask

    // Waits for the pulse, checks its width and verdict; dup issues a second request mid-run.
    task automatic detect(input bit expf, input string req, input bit dup);
        int  w = 0;
        int  extra = 0;
        pulse_start();
        if (dup) begin
            repeat (20) @(negedge clk_sys);
            start_req = 1'b1;
            @(negedge clk_sys) start_req = 1'b0;
        end
        while (!enable_o && w < 2000) begin
            @(negedge clk_sys);
            w++;
        end
        check(enable_o == 1'b1, "R4 pulse arrives", int'(enable_o), 1);
        check(fast_o == expf, req, int'(fast_o), int'(expf));
        @(negedge clk_sys);
        check(enable_o == 1'b0, "R4 pulse width", int'(enable_o), 0);
        repeat (300) begin
            @(negedge clk_sys);
            if (enable_o) extra++;
        end
        check(extra == 0, dup ? "R7 duplicate start ignored" : "R6 no extra pulse", extra, 0);
    endtask

    initial begin
        real rp;
        real op;
        bit  ef;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk_sys);
        check(enable_o == 1'b0, "R1 enable in reset", int'(enable_o), 0);
        check(fast_o == 1'b0, "R1 fast in reset", int'(fast_o), 0);
        rst = 1'b0;
        @(negedge clk_sys);
        check(enable_o == 1'b0 && fast_o == 1'b0, "R1 after reset",
              int'({enable_o, fast_o}), 0);

        set_clocks(100.0, 15.0);  detect(1'b1, "R2 fast extreme", 1'b0);
        set_clocks(80.0, 240.0);  detect(1'b0, "R3 slow extreme", 1'b0);
        set_clocks(90.0, 36.0);   detect(1'b1, "R2 fast band edge", 1'b0);
        set_clocks(60.0, 75.0);   detect(1'b0, "R3 slow band edge", 1'b0);

        // R5: a frequency change while holding must not disturb the verdict
        set_clocks(100.0, 20.0);  detect(1'b1, "R8 fresh fast verdict", 1'b0);
        set_clocks(100.0, 300.0);
        repeat (400) @(negedge clk_sys);
        check(fast_o == 1'b1 && enable_o == 1'b0, "R5 verdict held", int'(fast_o), 1);
        detect(1'b0, "R8 slow after fast", 1'b0);
        set_clocks(100.0, 25.0);  detect(1'b1, "R7 verdict with duplicate start", 1'b1);

        for (int i = 0; i < 14; i++) begin
            rp = 40.0 + $urandom_range(0, 80) + 0.37;
            if ($urandom_range(0, 1) == 1)
                op = rp * (0.15 + 0.25 * ($urandom_range(0, 1000) / 1000.0));
            else
                op = rp * (1.25 + 1.75 * ($urandom_range(0, 1000) / 1000.0));
            ef = exp_fast(op, rp);
            set_clocks(rp, op);
            detect(ef, ef ? "R2 random fast" : "R3 random slow", 1'b0);
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule